// File: doc/BRIEF.md
# Outstanding Miss Tracker with Requester Merging

This block is a small fully associative table of in-flight line transactions, indexed by line address. When several cores read the same missing line, the first one to arrive claims an entry and triggers a single downstream fetch. The cores that arrive later are added to the entry's requester bitmask and cause no further traffic. When the fill returns, the block sends one response that carries the data and the full requester bitmask, sends an unblock for the line, and releases the entry.

The same entries also track atomics that are forwarded downstream. An entry that holds an atomic keeps a count of the atomics still in flight. Each accepted atomic is forwarded and raises the count. Each returned result is routed to the core named in the return and lowers the count. When a return brings the count to zero, the block posts a completion trigger to itself and handles it one cycle later. At that point the entry is released if no new atomic has raised the count in the meantime. A lookup port reports the busy state of a live entry ahead of the tag state that the cache supplies.

Top module: `miss_tracker`

## Requirements
- R1: A request whose address matches no live entry claims the lowest-numbered free entry. The new entry's requester bitmask holds only the requesting core, and its atomic count is 1 for an atomic and 0 for a read.
- R2: A request of the same kind as a live entry with the same address uses no new entry. It sets the requesting core's bit in that entry's bitmask.
- R3: One cycle after an accepted read, `fetch_valid` pulses with the read's address if and only if the bitmask holds exactly one core after the add. This includes the case of a core repeating its own pending read.
- R4: One cycle after a fill that matches a live read entry, `rd_resp_valid` and `unblock_valid` pulse. The response carries the fill data and the entry's bitmask, where bit n stands for core n, and the unblock carries the fill address. The entry is released on the same edge.
- R5: One cycle after an accepted atomic, `afwd_valid` pulses with the atomic's address and core index, and the entry's atomic count rises by one.
- R6: One cycle after an atomic return that matches a live atomic entry whose count is not zero, `at_resp_valid` pulses. Its mask has only bit `aret_core` set, it carries `aret_data`, and the count falls by one.
- R7: A return that brings the count to zero posts a trigger. The entry stays live on the edge that takes the return and is released on the edge that follows.
- R8: If an atomic for the same line is accepted in the cycle the trigger is pending, the trigger is discarded and the entry stays live.
- R9: A request that matches no live entry while every entry is live raises `req_stall` in the same cycle. It allocates nothing and produces no fetch and no forward.
- R10: A request that matches a live entry of the other kind stalls. So does an atomic that matches an entry whose count is at its maximum. A stalled request changes no entry.
- R11: `look_state` is 3'b100 for a live read entry, 3'b101 for a live atomic entry, and {1'b0, look_tag} when no entry for the address is live.
- R12: A fill that matches no live read entry, and an atomic return that matches no live atomic entry, produce no response and change no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request from a core |
| req_atomic | input | 1 | 1 = atomic, 0 = read |
| req_addr | input | AW | Line address of the request |
| req_core | input | CW | Index of the requesting core |
| req_stall | output | 1 | Request not accepted this cycle |
| fetch_valid | output | 1 | Downstream line read |
| fetch_addr | output | AW | Address of the downstream read |
| afwd_valid | output | 1 | Atomic forwarded downstream |
| afwd_addr | output | AW | Address of the forwarded atomic |
| afwd_core | output | CW | Originating core of the forwarded atomic |
| fill_valid | input | 1 | Fill data returned from below |
| fill_addr | input | AW | Address of the fill |
| fill_data | input | DW | Fill data |
| rd_resp_valid | output | 1 | Multicast read response |
| rd_resp_mask | output | NCORES | Cores that receive the read response |
| rd_resp_data | output | DW | Read response data |
| unblock_valid | output | 1 | Unblock sent to the directory |
| unblock_addr | output | AW | Address of the unblock |
| aret_valid | input | 1 | Atomic result returned from below |
| aret_addr | input | AW | Address of the atomic result |
| aret_core | input | CW | Core that receives the atomic result |
| aret_data | input | DW | Atomic result data |
| at_resp_valid | output | 1 | Atomic response to a core |
| at_resp_mask | output | NCORES | One-hot target of the atomic response |
| at_resp_data | output | DW | Atomic response data |
| look_addr | input | AW | Address to look up |
| look_tag | input | 2 | Tag-array state for the looked-up address |
| look_state | output | 3 | Resolved state of the looked-up address |

## Verification
`req_stall` and `look_state` are combinational, so the bench samples them 1 ns after it drives the inputs, within the same cycle. Fetch, forward, read response, unblock and atomic response are all registered and are due exactly one edge after the input cycle. The driver queues the expected value of each of these before that edge, and the monitor compares it at the following falling edge. An output that arrives with nothing queued counts as a failure. An entry released by the drain trigger is due two edges after the draining return. The bench therefore does one lookup in the cycle between those two edges and another after the second edge, so that an early or a late release both show up.

// File: rtl/mt_pkg.sv
package mt_pkg;
  typedef enum logic { K_READ = 1'b0, K_ATOM = 1'b1 } mt_kind_e;

  localparam logic [2:0] LK_READ = 3'b100;
  localparam logic [2:0] LK_ATOM = 3'b101;
endpackage

// File: rtl/mt_pick.sv
module mt_pick #(
  parameter int N  = 4,
  parameter int IW = 2
) (
  input  logic [N-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = |req;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/mt_cam.sv
module mt_cam #(
  parameter int ENTRIES = 4,
  parameter int AW      = 16,
  parameter int IW      = 2
) (
  input  logic [ENTRIES-1:0]         live,
  input  logic [ENTRIES-1:0][AW-1:0] tags,
  input  logic [AW-1:0]              key,
  output logic                       hit,
  output logic [IW-1:0]              idx
);
  logic [ENTRIES-1:0] match;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = live[g] && (tags[g] == key);
  end

  mt_pick #(.N(ENTRIES), .IW(IW)) u_pick (.req(match), .any(hit), .idx(idx));
endmodule

// File: rtl/mt_entry.sv
module mt_entry
  import mt_pkg::*;
#(
  parameter int AW     = 16,
  parameter int NCORES = 4,
  parameter int CNTW   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  mt_kind_e          alloc_kind,
  input  logic [AW-1:0]     alloc_addr,
  input  logic              add_en,
  input  logic [NCORES-1:0] add_bit,
  input  logic              inc,
  input  logic              dec,
  input  logic              drop,
  output logic              live,
  output mt_kind_e          kind,
  output logic [AW-1:0]     addr,
  output logic [NCORES-1:0] dest,
  output logic [CNTW-1:0]   cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live <= 1'b0;
      kind <= K_READ;
      addr <= '0;
      dest <= '0;
      cnt  <= '0;
    end else if (drop) begin
      live <= 1'b0;
      dest <= '0;
      cnt  <= '0;
    end else if (alloc) begin
      // R1: requester set and count start clean, then take this request
      live <= 1'b1;
      kind <= alloc_kind;
      addr <= alloc_addr;
      dest <= add_bit;
      cnt  <= inc ? CNTW'(1) : '0;
    end else begin
      if (add_en) dest <= dest | add_bit;
      if (inc && !dec)      cnt <= cnt + CNTW'(1);
      else if (dec && !inc) cnt <= cnt - CNTW'(1);
    end
  end
endmodule

// File: rtl/miss_tracker.sv
module miss_tracker
  import mt_pkg::*;
#(
  parameter int ENTRIES = 4,
  parameter int NCORES  = 4,
  parameter int AW      = 16,
  parameter int DW      = 32,
  parameter int CNTW    = 4,
  localparam int CW     = (NCORES > 1) ? $clog2(NCORES) : 1,
  localparam int IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_atomic,
  input  logic [AW-1:0]     req_addr,
  input  logic [CW-1:0]     req_core,
  output logic              req_stall,
  output logic              fetch_valid,
  output logic [AW-1:0]     fetch_addr,
  output logic              afwd_valid,
  output logic [AW-1:0]     afwd_addr,
  output logic [CW-1:0]     afwd_core,
  input  logic              fill_valid,
  input  logic [AW-1:0]     fill_addr,
  input  logic [DW-1:0]     fill_data,
  output logic              rd_resp_valid,
  output logic [NCORES-1:0] rd_resp_mask,
  output logic [DW-1:0]     rd_resp_data,
  output logic              unblock_valid,
  output logic [AW-1:0]     unblock_addr,
  input  logic              aret_valid,
  input  logic [AW-1:0]     aret_addr,
  input  logic [CW-1:0]     aret_core,
  input  logic [DW-1:0]     aret_data,
  output logic              at_resp_valid,
  output logic [NCORES-1:0] at_resp_mask,
  output logic [DW-1:0]     at_resp_data,
  input  logic [AW-1:0]     look_addr,
  input  logic [1:0]        look_tag,
  output logic [2:0]        look_state
);
  localparam int PW = $clog2(NCORES + 1);

  function automatic logic [PW-1:0] pop_set(input logic [NCORES-1:0] v);
    logic [PW-1:0] n;
    n = '0;
    for (int i = 0; i < NCORES; i++) n = n + PW'(v[i]);
    return n;
  endfunction

  function automatic logic [NCORES-1:0] id_bit(input logic [CW-1:0] id);
    logic [NCORES-1:0] b;
    b = '0;
    b[id] = 1'b1;
    return b;
  endfunction

  // entry state
  logic [ENTRIES-1:0]             live_v;
  mt_kind_e                       kind_v [ENTRIES];
  logic [ENTRIES-1:0][AW-1:0]     addr_v;
  logic [ENTRIES-1:0][NCORES-1:0] dest_v;
  logic [ENTRIES-1:0][CNTW-1:0]   cnt_v;
  logic [ENTRIES-1:0]             alloc_v, add_v, inc_v, dec_v, drop_v;

  // named internal events
  logic              req_hit, fill_hit, ret_hit, look_hit, have_free;
  logic [IW-1:0]     req_idx, fill_idx, ret_idx, look_idx, free_idx;
  logic              req_go, fill_go, aret_go, first_req, drain_hit;
  logic              trig_v, trig_free, drop_any;
  logic [IW-1:0]     trig_idx;
  mt_kind_e          req_kind;
  logic [NCORES-1:0] req_bit, merged;

  mt_cam #(.ENTRIES(ENTRIES), .AW(AW), .IW(IW)) u_cam_req
    (.live(live_v), .tags(addr_v), .key(req_addr), .hit(req_hit), .idx(req_idx));
  mt_cam #(.ENTRIES(ENTRIES), .AW(AW), .IW(IW)) u_cam_fill
    (.live(live_v), .tags(addr_v), .key(fill_addr), .hit(fill_hit), .idx(fill_idx));
  mt_cam #(.ENTRIES(ENTRIES), .AW(AW), .IW(IW)) u_cam_ret
    (.live(live_v), .tags(addr_v), .key(aret_addr), .hit(ret_hit), .idx(ret_idx));
  mt_cam #(.ENTRIES(ENTRIES), .AW(AW), .IW(IW)) u_cam_look
    (.live(live_v), .tags(addr_v), .key(look_addr), .hit(look_hit), .idx(look_idx));
  mt_pick #(.N(ENTRIES), .IW(IW)) u_free
    (.req(~live_v), .any(have_free), .idx(free_idx));

  assign req_kind = req_atomic ? K_ATOM : K_READ;

  // R9, R10: full table, kind conflict or saturated count stall the request
  assign req_stall = req_valid &&
                     (req_hit ? ((kind_v[req_idx] != req_kind) ||
                                 (req_atomic && (cnt_v[req_idx] == {CNTW{1'b1}})))
                              : !have_free);
  assign req_go    = req_valid && !req_stall;
  assign req_bit   = id_bit(req_core);
  // R3: fetch only when the merged set holds a single core
  assign merged    = (req_hit ? dest_v[req_idx] : '0) | req_bit;
  assign first_req = (pop_set(merged) == PW'(1));

  // R4, R12: fill only acts on a live read entry
  assign fill_go   = fill_valid && fill_hit && (kind_v[fill_idx] == K_READ);
  // R6, R12: return only acts on a live atomic entry with work pending
  assign aret_go   = aret_valid && ret_hit && (kind_v[ret_idx] == K_ATOM) &&
                     (cnt_v[ret_idx] != '0);
  // R7: this return drains the counter
  assign drain_hit = aret_go && (cnt_v[ret_idx] == CNTW'(1)) && !inc_v[ret_idx];
  // R7, R8: deferred trigger frees only if the counter is still empty
  assign trig_free = trig_v && live_v[trig_idx] && (cnt_v[trig_idx] == '0) &&
                     !inc_v[trig_idx];
  assign drop_any  = fill_go || trig_free;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    assign alloc_v[g] = req_go && !req_hit && (free_idx == IW'(g));
    assign add_v[g]   = req_go && req_hit && (req_idx == IW'(g));
    assign inc_v[g]   = req_atomic && (alloc_v[g] || add_v[g]);
    assign dec_v[g]   = aret_go && (ret_idx == IW'(g));
    assign drop_v[g]  = (fill_go && (fill_idx == IW'(g))) ||
                        (trig_free && (trig_idx == IW'(g)));

    mt_entry #(.AW(AW), .NCORES(NCORES), .CNTW(CNTW)) u_ent (
      .clk(clk), .rst_n(rst_n),
      .alloc(alloc_v[g]), .alloc_kind(req_kind), .alloc_addr(req_addr),
      .add_en(add_v[g]), .add_bit(req_bit),
      .inc(inc_v[g]), .dec(dec_v[g]), .drop(drop_v[g]),
      .live(live_v[g]), .kind(kind_v[g]), .addr(addr_v[g]),
      .dest(dest_v[g]), .cnt(cnt_v[g])
    );
  end

  // R11: a live entry overrides the tag state
  always_comb begin
    if (look_hit) look_state = (kind_v[look_idx] == K_ATOM) ? LK_ATOM : LK_READ;
    else          look_state = {1'b0, look_tag};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_valid   <= 1'b0;
      fetch_addr    <= '0;
      afwd_valid    <= 1'b0;
      afwd_addr     <= '0;
      afwd_core     <= '0;
      rd_resp_valid <= 1'b0;
      rd_resp_mask  <= '0;
      rd_resp_data  <= '0;
      unblock_valid <= 1'b0;
      unblock_addr  <= '0;
      at_resp_valid <= 1'b0;
      at_resp_mask  <= '0;
      at_resp_data  <= '0;
      trig_v        <= 1'b0;
      trig_idx      <= '0;
    end else begin
      fetch_valid   <= req_go && !req_atomic && first_req;
      fetch_addr    <= req_addr;
      afwd_valid    <= req_go && req_atomic;
      afwd_addr     <= req_addr;
      afwd_core     <= req_core;
      rd_resp_valid <= fill_go;
      rd_resp_mask  <= dest_v[fill_idx];
      rd_resp_data  <= fill_data;
      unblock_valid <= fill_go;
      unblock_addr  <= fill_addr;
      at_resp_valid <= aret_go;
      at_resp_mask  <= id_bit(aret_core);
      at_resp_data  <= aret_data;
      trig_v        <= drain_hit;
      trig_idx      <= ret_idx;
    end
  end
endmodule

// File: rtl/miss_tracker_chk.sv
module miss_tracker_chk #(
  parameter int ENTRIES = 4,
  parameter int NCORES  = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_stall,
  input logic               fetch_valid,
  input logic               afwd_valid,
  input logic               rd_resp_valid,
  input logic [NCORES-1:0]  rd_resp_mask,
  input logic               at_resp_valid,
  input logic [NCORES-1:0]  at_resp_mask,
  input logic [ENTRIES-1:0] live_v,
  input logic               trig_v,
  input logic               aret_go,
  input logic               drop_any
);
  p_stall_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_stall |=> (!fetch_valid && !afwd_valid));

  p_fetch_from_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> ($past(req_valid) && !$past(req_stall)));

  p_fill_has_dest_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_resp_valid |-> (rd_resp_mask != '0));

  p_atom_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    at_resp_valid |-> ($countones(at_resp_mask) == 1));

  p_trig_after_ret_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_v |-> $past(aret_go));

  p_occ_only_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(drop_any) |-> ($countones(live_v) >= $past($countones(live_v))));
endmodule

bind miss_tracker miss_tracker_chk #(.ENTRIES(ENTRIES), .NCORES(NCORES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_stall(req_stall),
  .fetch_valid(fetch_valid), .afwd_valid(afwd_valid),
  .rd_resp_valid(rd_resp_valid), .rd_resp_mask(rd_resp_mask),
  .at_resp_valid(at_resp_valid), .at_resp_mask(at_resp_mask),
  .live_v(live_v), .trig_v(trig_v), .aret_go(aret_go), .drop_any(drop_any)
);

// File: tb/sim_miss_tracker.sv
module sim_miss_tracker;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int E  = 4;
  localparam int NC = 4;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_atomic = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [CW-1:0] req_core = '0;
  logic req_stall, fetch_valid, afwd_valid, rd_resp_valid, unblock_valid, at_resp_valid;
  logic [AW-1:0] fetch_addr, afwd_addr, unblock_addr;
  logic [CW-1:0] afwd_core;
  logic fill_valid = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic [DW-1:0] fill_data = '0;
  logic [NC-1:0] rd_resp_mask, at_resp_mask;
  logic [DW-1:0] rd_resp_data, at_resp_data;
  logic aret_valid = 1'b0;
  logic [AW-1:0] aret_addr = '0;
  logic [CW-1:0] aret_core = '0;
  logic [DW-1:0] aret_data = '0;
  logic [AW-1:0] look_addr = '0;
  logic [1:0] look_tag = '0;
  logic [2:0] look_state;

  int checks = 0;
  int fails = 0;
  bit fin = 1'b0;

  logic [AW-1:0]         q_fetch [$];
  logic [AW+CW-1:0]      q_afwd  [$];
  logic [NC+DW+AW-1:0]   q_rd    [$];
  logic [NC+DW-1:0]      q_at    [$];

  always #10 clk = ~clk;

  miss_tracker #(.ENTRIES(E), .NCORES(NC), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_atomic(req_atomic), .req_addr(req_addr),
    .req_core(req_core), .req_stall(req_stall),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .afwd_valid(afwd_valid), .afwd_addr(afwd_addr), .afwd_core(afwd_core),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .rd_resp_valid(rd_resp_valid), .rd_resp_mask(rd_resp_mask), .rd_resp_data(rd_resp_data),
    .unblock_valid(unblock_valid), .unblock_addr(unblock_addr),
    .aret_valid(aret_valid), .aret_addr(aret_addr), .aret_core(aret_core),
    .aret_data(aret_data), .at_resp_valid(at_resp_valid), .at_resp_mask(at_resp_mask),
    .at_resp_data(at_resp_data), .look_addr(look_addr), .look_tag(look_tag),
    .look_state(look_state)
  );

  task automatic chk(input string tag, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as registered results appear
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      if (fetch_valid) begin
        if (q_fetch.size() == 0) chk("R3 unexpected fetch", 1'b0, 64'(fetch_addr), 64'h0);
        else begin
          logic [AW-1:0] e;
          e = q_fetch.pop_front();
          chk("R3 fetch addr", fetch_addr == e, 64'(fetch_addr), 64'(e));
        end
      end
      if (afwd_valid) begin
        if (q_afwd.size() == 0) chk("R5 unexpected forward", 1'b0, 64'({afwd_addr, afwd_core}), 64'h0);
        else begin
          logic [AW+CW-1:0] e;
          e = q_afwd.pop_front();
          chk("R5 forward", {afwd_addr, afwd_core} == e, 64'({afwd_addr, afwd_core}), 64'(e));
        end
      end
      if (rd_resp_valid || unblock_valid) begin
        chk("R4 unblock with response", rd_resp_valid == unblock_valid,
            64'(unblock_valid), 64'(rd_resp_valid));
        if (q_rd.size() == 0)
          chk("R12 unexpected read response", 1'b0, 64'(rd_resp_mask), 64'h0);
        else begin
          logic [NC+DW+AW-1:0] e;
          e = q_rd.pop_front();
          chk("R4 read response", {rd_resp_mask, rd_resp_data, unblock_addr} == e,
              64'({rd_resp_mask, rd_resp_data, unblock_addr}), 64'(e));
        end
      end
      if (at_resp_valid) begin
        if (q_at.size() == 0) chk("R12 unexpected atomic response", 1'b0, 64'(at_resp_mask), 64'h0);
        else begin
          logic [NC+DW-1:0] e;
          e = q_at.pop_front();
          chk("R6 atomic response", {at_resp_mask, at_resp_data} == e,
              64'({at_resp_mask, at_resp_data}), 64'(e));
        end
      end
    end
  end

  task automatic drv_req(input bit atom, input logic [AW-1:0] a, input logic [CW-1:0] c,
                         input bit exp_stall, input bit exp_fetch, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_atomic = atom; req_addr = a; req_core = c;
    #1 chk(tag, req_stall == exp_stall, 64'(req_stall), 64'(exp_stall));
    if (!exp_stall) begin
      if (!atom && exp_fetch) q_fetch.push_back(a);
      if (atom) q_afwd.push_back({a, c});
    end
    @(posedge clk); #1 req_valid = 1'b0;
  endtask

  task automatic drv_fill(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input bit exp_hit, input logic [NC-1:0] exp_mask);
    @(negedge clk);
    fill_valid = 1'b1; fill_addr = a; fill_data = d;
    if (exp_hit) q_rd.push_back({exp_mask, d, a});
    @(posedge clk); #1 fill_valid = 1'b0;
  endtask

  task automatic drv_ret(input logic [AW-1:0] a, input logic [CW-1:0] c,
                         input logic [DW-1:0] d, input bit exp_hit);
    @(negedge clk);
    aret_valid = 1'b1; aret_addr = a; aret_core = c; aret_data = d;
    if (exp_hit) q_at.push_back({NC'(1) << c, d});
    @(posedge clk); #1 aret_valid = 1'b0;
  endtask

  task automatic look_chk(input logic [AW-1:0] a, input logic [1:0] t,
                          input logic [2:0] exp, input string tag);
    @(negedge clk);
    look_addr = a; look_tag = t;
    #1 chk(tag, look_state == exp, 64'(look_state), 64'(exp));
  endtask

  task automatic quiet_chk(input string tag);
    @(negedge clk);
    #1 chk(tag, !(fetch_valid || afwd_valid || rd_resp_valid || unblock_valid || at_resp_valid),
           64'({fetch_valid, afwd_valid, rd_resp_valid, unblock_valid, at_resp_valid}), 64'h0);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!fin) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // reset state
    quiet_chk("R1 reset outputs idle");
    look_chk(16'h0100, 2'b11, 3'b011, "R11 reset lookup passes tag");

    // read merging on line A
    drv_req(1'b0, 16'h0100, 2'd0, 1'b0, 1'b1, "R1 first read accepted");
    look_chk(16'h0100, 2'b00, 3'b100, "R11 read pending");
    drv_req(1'b0, 16'h0100, 2'd2, 1'b0, 1'b0, "R2 merged read accepted");
    drv_req(1'b0, 16'h0100, 2'd0, 1'b0, 1'b0, "R3 repeat in two-core set");
    drv_fill(16'h0100, 32'hA5A5_0001, 1'b1, 4'b0101);
    look_chk(16'h0100, 2'b01, 3'b001, "R4 entry released after fill");

    // same core repeats its own pending read: set still one member
    drv_req(1'b0, 16'h0200, 2'd1, 1'b0, 1'b1, "R3 read B");
    drv_req(1'b0, 16'h0200, 2'd1, 1'b0, 1'b1, "R3 same core refetches");
    drv_fill(16'h0200, 32'h0000_BEEF, 1'b1, 4'b0010);

    // atomics on line C
    drv_req(1'b1, 16'h0300, 2'd3, 1'b0, 1'b0, "R5 atomic allocates");
    drv_req(1'b1, 16'h0300, 2'd1, 1'b0, 1'b0, "R5 second atomic");
    drv_req(1'b0, 16'h0300, 2'd0, 1'b1, 1'b0, "R10 read to atomic line stalls");
    quiet_chk("R10 stalled read issues nothing");
    look_chk(16'h0300, 2'b00, 3'b101, "R11 atomic pending");
    drv_fill(16'h0300, 32'h1234_5678, 1'b0, 4'b0000);
    quiet_chk("R12 fill to atomic line ignored");
    drv_ret(16'h0300, 2'd3, 32'h0000_0C03, 1'b1);
    look_chk(16'h0300, 2'b10, 3'b101, "R6 entry live with one atomic left");
    drv_ret(16'h0300, 2'd1, 32'h0000_0C01, 1'b1);
    look_chk(16'h0300, 2'b10, 3'b101, "R7 live while trigger pending");
    look_chk(16'h0300, 2'b10, 3'b010, "R7 released after trigger");

    // trigger discarded by a new atomic on line D
    drv_req(1'b1, 16'h0400, 2'd0, 1'b0, 1'b0, "R5 atomic D");
    drv_ret(16'h0400, 2'd0, 32'h0000_0D00, 1'b1);
    drv_req(1'b1, 16'h0400, 2'd2, 1'b0, 1'b0, "R8 atomic during pending trigger");
    look_chk(16'h0400, 2'b00, 3'b101, "R8 entry kept");
    look_chk(16'h0400, 2'b00, 3'b101, "R8 entry still kept");
    drv_ret(16'h0400, 2'd2, 32'h0000_0D02, 1'b1);
    look_chk(16'h0400, 2'b01, 3'b101, "R7 D pending trigger");
    look_chk(16'h0400, 2'b01, 3'b001, "R7 D released");

    // unmatched return
    drv_ret(16'h0999, 2'd1, 32'hDEAD_0000, 1'b0);
    quiet_chk("R12 unmatched return ignored");
    drv_fill(16'h0777, 32'hDEAD_0001, 1'b0, 4'b0000);
    quiet_chk("R12 unmatched fill ignored");

    // full table
    drv_req(1'b0, 16'h0501, 2'd0, 1'b0, 1'b1, "R1 fill table 1");
    drv_req(1'b0, 16'h0502, 2'd1, 1'b0, 1'b1, "R1 fill table 2");
    drv_req(1'b0, 16'h0503, 2'd2, 1'b0, 1'b1, "R1 fill table 3");
    drv_req(1'b0, 16'h0504, 2'd3, 1'b0, 1'b1, "R1 fill table 4");
    drv_req(1'b0, 16'h0505, 2'd0, 1'b1, 1'b0, "R9 miss on full table stalls");
    quiet_chk("R9 stalled miss issues nothing");
    drv_req(1'b1, 16'h0501, 2'd2, 1'b1, 1'b0, "R10 atomic to read line stalls");
    drv_req(1'b0, 16'h0502, 2'd3, 1'b0, 1'b0, "R2 merge while full");
    drv_fill(16'h0501, 32'h5000_0001, 1'b1, 4'b0001);
    drv_req(1'b0, 16'h0505, 2'd0, 1'b0, 1'b1, "R1 allocation after release");
    drv_fill(16'h0502, 32'h5000_0002, 1'b1, 4'b1010);
    drv_fill(16'h0503, 32'h5000_0003, 1'b1, 4'b0100);
    drv_fill(16'h0504, 32'h5000_0004, 1'b1, 4'b1000);
    drv_fill(16'h0505, 32'h5000_0005, 1'b1, 4'b0001);
    look_chk(16'h0505, 2'b11, 3'b011, "R4 last entry released");

    repeat (3) @(negedge clk);
    chk("R3 all fetches seen", q_fetch.size() == 0, 64'(q_fetch.size()), 64'h0);
    chk("R5 all forwards seen", q_afwd.size() == 0, 64'(q_afwd.size()), 64'h0);
    chk("R4 all read responses seen", q_rd.size() == 0, 64'(q_rd.size()), 64'h0);
    chk("R6 all atomic responses seen", q_at.size() == 0, 64'(q_at.size()), 64'h0);

    fin = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule